// File: doc/BRIEF.md
# Byte-Wide APB GPIO Port with Address-Masked Data Access

This block is an eight-line general-purpose I/O port on an APB slave. A direction register makes each line an input or an output. An output data register drives the pad output values. Pad inputs pass through a multi-flop synchronizer before any read can see them.

The data register has no single address. It is reached through a 256-word window, and address bits [9:2] of every access form a per-pin mask. Software can therefore set, clear or sample any subset of pins in one bus transfer, with no read-modify-write sequence and no race against other agents that drive the same port. Every transfer finishes in the access phase without wait states. All data moves on bits [7:0] of the bus.

Top module: `gpiom_apb_gpio`

## Requirements
- R1: A synchronous active-high reset clears the direction and output data registers and the synchronizer, so every pad output-enable and every pad output value is 0.
- R2: A write access (psel, penable and pwrite all high) whose address has bits [11:10] equal to 0 updates output data bit i from pwdata[i] only where paddr[2+i] is 1. All other output data bits keep their value.
- R3: During a read access to that data window, result bit i is 0 wherever paddr[2+i] is 0.
- R4: During a data-window read, an unmasked bit i returns the output data bit when direction bit i is 1, and the synchronized pad input when it is 0.
- R5: The direction register sits at byte offset 0x400 (paddr[11:2] = 0x100). It is written from pwdata[7:0] and reads back in full. pad_oe[i] equals direction bit i.
- R6: pad_out[i] always equals output data bit i, whatever the direction.
- R7: A change on pad_in becomes visible to data reads after exactly two rising clock edges, and not after one.
- R8: pready is always 1 and pslverr is always 0.
- R9: Reads of any other offset return 0, and writes to any other offset change no register.
- R10: prdata[31:8] is always 0, and pwdata[31:8] has no effect.
- R11: prdata is 0 outside a read access phase, and a write takes effect only in the access phase. A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
Two things can happen on the same clock edge: a masked data write, and a synchronizer update that brings a new pad input value into the read path. The bench provokes this by changing pad_in during the setup phase of a data write, so that the synchronized value and the register update both land on the commit edge. A full-mask read that follows must show the new output bits on output pins and the new input bits on input pins. A behavioural model with a two-deep input history judges every cycle, and it also runs a long random mix of reads, writes, direction changes and pad toggles.

// File: rtl/gpiom_pkg.sv
package gpiom_pkg;

    // Line count is fixed by the address-mask field paddr[9:2]
    localparam int GPIO_PINS   = 8;
    localparam int MASK_LSB    = 2;
    localparam int WINDOW_MSB  = MASK_LSB + GPIO_PINS - 1;   // 9
    localparam int DIR_WORD    = 'h100;                      // byte 0x400

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DATA = 2'd1,
        TGT_DIR  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [GPIO_PINS-1:0] mask;
        logic                 wr;
        logic                 rd;
    } bus_req_t;

    // Per-pin value seen by a data read: output register on outputs,
    // synchronized pad on inputs
    function automatic logic [GPIO_PINS-1:0] pin_view(
        input logic [GPIO_PINS-1:0] dir,
        input logic [GPIO_PINS-1:0] dout,
        input logic [GPIO_PINS-1:0] sync_in
    );
        return (dir & dout) | (~dir & sync_in);
    endfunction

    // Masked merge of new write data into a register
    function automatic logic [GPIO_PINS-1:0] masked_merge(
        input logic [GPIO_PINS-1:0] old_v,
        input logic [GPIO_PINS-1:0] new_v,
        input logic [GPIO_PINS-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/gpiom_decode.sv
module gpiom_decode
    import gpiom_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output bus_req_t          req
);
    localparam int WORD_W = ADDR_W - MASK_LSB;

    logic in_window;
    logic is_dir;
    logic access;

    assign in_window = (paddr[ADDR_W-1:WINDOW_MSB+1] == '0);
    assign is_dir    = (paddr[ADDR_W-1:MASK_LSB] == WORD_W'(DIR_WORD));
    assign access    = psel && penable;

    always_comb begin
        req      = '0;
        req.mask = paddr[WINDOW_MSB:MASK_LSB];
        if (in_window)   req.tgt = TGT_DATA;
        else if (is_dir) req.tgt = TGT_DIR;
        else             req.tgt = TGT_NONE;
        req.wr = access && pwrite;
        req.rd = access && !pwrite;
    end

endmodule

// File: rtl/gpiom_sync.sv
module gpiom_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpiom_regs.sv
module gpiom_regs
    import gpiom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    input  logic [GPIO_PINS-1:0] wbyte,
    output logic [GPIO_PINS-1:0] dir_q,
    output logic [GPIO_PINS-1:0] dout_q
);
    logic dir_we;
    logic dat_we;

    assign dir_we = req.wr && (req.tgt == TGT_DIR);
    assign dat_we = req.wr && (req.tgt == TGT_DATA);

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_we) dir_q <= wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst)         dout_q <= '0;
        else if (dat_we) dout_q <= masked_merge(dout_q, wbyte, req.mask);
    end

endmodule

// File: rtl/gpiom_apb_gpio.sv
module gpiom_apb_gpio
    import gpiom_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic [GPIO_PINS-1:0] pad_in,
    output logic [GPIO_PINS-1:0] pad_out,
    output logic [GPIO_PINS-1:0] pad_oe
);
    bus_req_t             req;
    logic [GPIO_PINS-1:0] dir_q;
    logic [GPIO_PINS-1:0] dout_q;
    logic [GPIO_PINS-1:0] pad_sync;
    logic [GPIO_PINS-1:0] rbyte;
    logic                 unused_bits;

    assign unused_bits = ^{pwdata[DATA_W-1:GPIO_PINS], paddr[MASK_LSB-1:0]};

    gpiom_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .req     (req)
    );

    gpiom_sync #(.WIDTH(GPIO_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    gpiom_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wbyte  (pwdata[GPIO_PINS-1:0]),
        .dir_q  (dir_q),
        .dout_q (dout_q)
    );

    always_comb begin
        unique case (req.tgt)
            TGT_DATA: rbyte = pin_view(dir_q, dout_q, pad_sync) & req.mask;
            TGT_DIR:  rbyte = dir_q;
            default:  rbyte = '0;
        endcase
    end

    assign prdata  = req.rd ? {{(DATA_W-GPIO_PINS){1'b0}}, rbyte} : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpiom_apb_gpio_chk.sv
module gpiom_apb_gpio_chk
    import gpiom_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [DATA_W-1:0]    pwdata,
    input logic [DATA_W-1:0]    prdata,
    input logic                 pready,
    input logic                 pslverr,
    input logic [GPIO_PINS-1:0] pad_in,
    input logic [GPIO_PINS-1:0] pad_out,
    input logic [GPIO_PINS-1:0] pad_oe
);
    logic                 wr_acc;
    logic                 rd_acc;
    logic                 win;
    logic [GPIO_PINS-1:0] msk;

    assign wr_acc = psel && penable && pwrite;
    assign rd_acc = psel && penable && !pwrite;
    assign win    = (paddr[ADDR_W-1:WINDOW_MSB+1] == '0);
    assign msk    = paddr[WINDOW_MSB:MASK_LSB];

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && win) |=> ((pad_out & ~$past(msk)) == ($past(pad_out) & ~$past(msk)))); // R2

    AST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && win) |-> ((prdata[GPIO_PINS-1:0] & ~msk) == '0)); // R3

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && paddr == ADDR_W'('h400)) |=> (pad_oe == $past(pwdata[GPIO_PINS-1:0]))); // R5

    AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        prdata[DATA_W-1:GPIO_PINS] == '0); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_acc |=> ($stable(pad_out) && $stable(pad_oe))); // R11

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |-> (prdata == '0)); // R11

endmodule

bind gpiom_apb_gpio gpiom_apb_gpio_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (.*);

// File: tb/gpiom_apb_gpio_tb_top.sv
`timescale 1ns/1ps
module gpiom_apb_gpio_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gpiom_apb_gpio dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int      m_dir  = 0;
    int      m_dout = 0;
    int      m_hist[$];

    function automatic int m_sync();
        return (m_hist.size() >= 2) ? m_hist[0] : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 0; m_dout = 0; m_hist.delete();
        end else begin
            int a;
            int m;
            a = int'(paddr);
            m = (a >> 2) & 'hFF;
            if (psel && penable && pwrite) begin
                if (a < 'h400)            m_dout = (m_dout & ~m) | (int'(pwdata) & m & 'hFF);
                else if ((a >> 2) == 'h100) m_dir = int'(pwdata) & 'hFF;
            end
            m_hist.push_back(int'(pad_in));
            if (m_hist.size() > 2) void'(m_hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int a;
            int exp_rd;
            a = int'(paddr);
            chk("R5 pad_oe", 32'(pad_oe), 32'(m_dir));
            chk("R6 pad_out", 32'(pad_out), 32'(m_dout));
            chk("R8 ready/err", {30'd0, pready, pslverr}, 32'h2);
            if (psel && penable && !pwrite) begin
                if (a < 'h400) begin
                    exp_rd = ((m_dir & m_dout) | (~m_dir & m_sync())) & (a >> 2) & 'hFF;
                    chk("R3/R4 data read", prdata, 32'(exp_rd));
                end else if ((a >> 2) == 'h100) begin
                    chk("R5 dir read", prdata, 32'(m_dir));
                end else begin
                    chk("R9 unmapped read", prdata, 32'h0);
                end
            end else begin
                chk("R11 idle prdata", prdata, 32'h0);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1; penable = 1;
        @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1; penable = 1;
        @(negedge clk); d = prdata;
        @(posedge clk); #1; psel = 0; penable = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        done = 1;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        chk("R1 pad_out after reset", 32'(pad_out), 32'h0);
        bus_rd(12'h400, r); chk("R1 dir reads 0", r, 32'h0);

        bus_wr(12'h400, 32'h0F); bus_rd(12'h400, r);
        chk("R5 dir readback", r, 32'h0F);
        chk("R5 oe follows dir", 32'(pad_oe), 32'h0F);

        bus_wr(12'h3FC, 32'hA5);
        @(negedge clk); chk("R6 pad_out full write", 32'(pad_out), 32'hA5);
        bus_wr(12'h030, 32'h00);                    // mask 0x0C
        @(negedge clk); chk("R2 masked clear", 32'(pad_out), 32'hA1);

        @(posedge clk); #1 pad_in = 8'h3C;
        repeat (3) @(posedge clk);
        bus_rd(12'h3FC, r); chk("R4 mixed source read", r, 32'h31);
        bus_rd(12'h0C0, r); chk("R3 masked read", r, 32'h30);

        // R7: hold a read access open and watch the synchronizer latency
        @(posedge clk); #1 psel = 1; penable = 1; pwrite = 0; paddr = 12'h3FC;
        @(posedge clk); #1 pad_in = 8'hC0;
        @(negedge clk); chk("R7 no edge yet", prdata, 32'h31);
        @(negedge clk); chk("R7 one edge", prdata, 32'h31);
        @(negedge clk); chk("R7 two edges", prdata, 32'hC1);
        @(posedge clk); #1 psel = 0; penable = 0;

        bus_wr(12'h800, 32'hFF); bus_wr(12'h404, 32'hFF);
        bus_rd(12'h800, r); chk("R9 unmapped read zero", r, 32'h0);
        bus_rd(12'h400, r); chk("R9 dir untouched", r, 32'h0F);
        chk("R9 data untouched", 32'(pad_out), 32'hA1);

        bus_wr(12'h400, 32'hFFFF_FF00);
        bus_rd(12'h400, r); chk("R10 upper wdata ignored", r, 32'h0);
        bus_wr(12'h400, 32'h0F);

        @(posedge clk); #1 psel = 1; penable = 0; pwrite = 1; paddr = 12'h400; pwdata = 32'hFF;
        @(posedge clk); #1 psel = 0; pwrite = 0;
        @(negedge clk); chk("R11 setup-only write ignored", 32'(pad_oe), 32'h0F);

        // write commit edge coincides with synchronizer update
        fork
            bus_wr(12'h044, 32'h10);                // mask pins 0 and 4
            begin @(posedge clk); #1 pad_in = 8'h50; end
        join
        chk("R2 concurrent write", 32'(pad_out), 32'hB0);
        bus_rd(12'h3FC, r); chk("R4 concurrent read", r, 32'h50);

        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) begin @(posedge clk); #1 pad_in = 8'($urandom); end
            case (k)
                0, 1, 2: bus_wr(12'($urandom_range(0, 255) << 2), $urandom);
                3:       bus_wr(12'h400, $urandom);
                4:       bus_wr(12'h400 + 12'($urandom_range(1, 255) << 2), $urandom);
                5, 6, 7: bus_rd(12'($urandom_range(0, 255) << 2), r);
                8:       bus_rd(12'h400, r);
                default: bus_rd(12'h400 + 12'($urandom_range(1, 255) << 2), r);
            endcase
        end

        repeat (2) @(posedge clk);
        done = 1;
    end

    initial begin
        wait (done);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule